// File: doc/BRIEF.md
# Memory Slot Hotplug Pending Map and Event Controller

This block is an I/O-port register block. Firmware and the operating system read it to learn which memory slots have a hotplug notification waiting. It keeps one pending bit per slot, for up to `SLOTS` slots (256 by default). The host reads these bits one byte at a time through a read-only window on a byte-wide port bus.

A hot-add event names a slot. That event sets the slot's pending bit and latches the memory-hotplug bit of a general-purpose event status byte. A separate source, the PCI hotplug event, latches its own status bit. Both status bits are masked by an enable byte, and the result is ORed with the existing power-management interrupt request to form a registered, level-sensitive system control interrupt (SCI).

When the OS finishes removing a slot, it writes the slot index to a write-only eject byte. The block then clears that slot's pending bit and announces the index on an eject output with a one-cycle strobe.

Top module: `memhp_ctrl`

## Requirements
- R1: After a synchronous reset, every pending bit, the event status byte, the enable byte, `io_rdata`, `sci` and `eject_valid` are zero.
- R2: A hot-add of slot n sets bit (n mod 8) of the pending byte at port `MAP_BASE` + (n div 8), default window 0xAF80 to 0xAF9F. A read strobe in cycle k presents that byte on `io_rdata` from the following clock edge.
- R3: Writes to the pending window have no effect on any pending bit.
- R4: A hot-add sets event status bit 3 (mask 0x08). A `pci_hp_evt` pulse sets event status bit 1 (mask 0x02). No other status bit is ever set. The status byte is read at `STS_ADDR` (default 0xAFE0).
- R5: `sci` is high exactly one cycle after a cycle in which `pm_sci_in` was high, or in which (status AND enable AND 0x0A) was nonzero.
- R6: Writing the status byte clears each status bit whose write-data bit is 1 and leaves bits written 0 unchanged. `sci` drops the cycle after the bit clears. A hot-add in the same cycle as a clear of bit 3 leaves bit 3 set.
- R7: A read of any port that is not the pending window, the status byte or the enable byte returns 0. This includes ports just past the window and the eject byte.
- R8: A write to `EJECT_ADDR` (default 0xAFA0) raises `eject_valid` for one cycle at the next edge, with `eject_slot` equal to the written data. It clears only that slot's pending bit.
- R9: When a hot-add and a read of the same pending byte happen in the same cycle, the read returns the value before the update, and the next read shows the new bit.
- R10: The enable byte at `EN_ADDR` (default 0xAFE1) is fully readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |
| hp_add_valid | input | 1 | Hot-add event strobe |
| hp_add_slot | input | SLOT_W | Slot index of the hot-add |
| pci_hp_evt | input | 1 | PCI hotplug event strobe |
| pm_sci_in | input | 1 | Other power-management interrupt request |
| eject_valid | output | 1 | One-cycle eject strobe |
| eject_slot | output | SLOT_W | Slot index being ejected |
| sci | output | 1 | Level system control interrupt |

## Verification
The hardest case to reach from the ports is a set and a clear landing on the same storage in the same edge.

The bench reaches it with two collisions. First, it drives a hot-add together with a write-1 clear of the status byte in one cycle. Second, it drives a hot-add together with a read of the very byte being updated. In each case it then reads back both the status and the pending byte, which shows that set wins over clear and that the read saw the old value.

Eject is checked against a byte that holds other set bits, so a clear that is too wide would be visible.

// File: rtl/memhp_pkg.sv
package memhp_pkg;
  localparam int GPE_PCI_BIT = 1;
  localparam int GPE_MEM_BIT = 3;
  localparam logic [7:0] SCI_MASK = 8'h0A;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MAP,
    SEL_EJECT,
    SEL_STS,
    SEL_EN
  } sel_e;
endpackage

// File: rtl/memhp_decode.sv
module memhp_decode
  import memhp_pkg::*;
#(
  parameter int          MAP_BYTES  = 32,
  parameter logic [15:0] MAP_BASE   = 16'hAF80,
  parameter logic [15:0] EJECT_ADDR = 16'hAFA0,
  parameter logic [15:0] STS_ADDR   = 16'hAFE0,
  parameter logic [15:0] EN_ADDR    = 16'hAFE1,
  localparam int         IDX_W      = (MAP_BYTES > 1) ? $clog2(MAP_BYTES) : 1
) (
  input  logic [15:0]      addr,
  output sel_e             sel,
  output logic [IDX_W-1:0] byte_idx
);
  logic [15:0] off;

  always_comb begin
    off      = addr - MAP_BASE;
    byte_idx = off[IDX_W-1:0];
    if (off < 16'(MAP_BYTES))  sel = SEL_MAP;
    else if (addr == EJECT_ADDR) sel = SEL_EJECT;
    else if (addr == STS_ADDR)   sel = SEL_STS;
    else if (addr == EN_ADDR)    sel = SEL_EN;
    else                         sel = SEL_NONE;
  end
endmodule

// File: rtl/memhp_bitmap.sv
module memhp_bitmap #(
  parameter int SLOTS  = 256,
  localparam int BYTES  = SLOTS / 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_valid,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic              clr_valid,
  input  logic [SLOT_W-1:0] clr_slot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_byte,
  output logic [SLOTS-1:0]  pend_flat
);
  logic [BYTES-1:0][7:0] bytes_q;

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    localparam logic [SLOT_W-4:0] GIDX = (SLOT_W-3)'(g);
    logic [7:0] set_m;
    logic [7:0] clr_m;
    logic [7:0] q;

    always_comb begin
      set_m = (set_valid && set_slot[SLOT_W-1:3] == GIDX) ? (8'b1 << set_slot[2:0]) : 8'h00;
      clr_m = (clr_valid && clr_slot[SLOT_W-1:3] == GIDX) ? (8'b1 << clr_slot[2:0]) : 8'h00;
    end

    // set has priority over clear so that a fresh event is never lost
    always_ff @(posedge clk) begin
      if (rst) q <= 8'h00;
      else     q <= (q & ~clr_m) | set_m;
    end

    assign bytes_q[g] = q;
  end

  assign rd_byte   = bytes_q[rd_idx];
  assign pend_flat = bytes_q;
endmodule

// File: rtl/memhp_gpe.sv
module memhp_gpe
  import memhp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mem_evt,
  input  logic       pci_evt,
  input  logic       sts_wr,
  input  logic       en_wr,
  input  logic [7:0] wdata,
  input  logic       pm_sci_in,
  output logic [7:0] sts,
  output logic [7:0] en,
  output logic       sci
);
  logic [7:0] set_m;
  logic [7:0] clr_m;

  always_comb begin
    set_m              = 8'h00;
    set_m[GPE_MEM_BIT] = mem_evt;
    set_m[GPE_PCI_BIT] = pci_evt;
    clr_m              = sts_wr ? wdata : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= 8'h00;
      en  <= 8'h00;
      sci <= 1'b0;
    end else begin
      sts <= (sts & ~clr_m) | set_m;
      if (en_wr) en <= wdata;
      sci <= pm_sci_in | (|(sts & en & SCI_MASK));
    end
  end
endmodule

// File: rtl/memhp_ctrl.sv
module memhp_ctrl
  import memhp_pkg::*;
#(
  parameter int          SLOTS      = 256,
  parameter logic [15:0] MAP_BASE   = 16'hAF80,
  parameter logic [15:0] EJECT_ADDR = 16'hAFA0,
  parameter logic [15:0] STS_ADDR   = 16'hAFE0,
  parameter logic [15:0] EN_ADDR    = 16'hAFE1,
  localparam int         SLOT_W     = $clog2(SLOTS),
  localparam int         MAP_BYTES  = SLOTS / 8,
  localparam int         IDX_W      = (MAP_BYTES > 1) ? $clog2(MAP_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              hp_add_valid,
  input  logic [SLOT_W-1:0] hp_add_slot,
  input  logic              pci_hp_evt,
  input  logic              pm_sci_in,
  output logic              eject_valid,
  output logic [SLOT_W-1:0] eject_slot,
  output logic              sci
);
  sel_e             sel;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       map_byte;
  logic [SLOTS-1:0] pend_flat;
  logic [7:0]       gpe_sts;
  logic [7:0]       gpe_en;
  logic             ej_hit;

  assign ej_hit = io_wr && (sel == SEL_EJECT);

  memhp_decode #(
    .MAP_BYTES(MAP_BYTES), .MAP_BASE(MAP_BASE), .EJECT_ADDR(EJECT_ADDR),
    .STS_ADDR(STS_ADDR), .EN_ADDR(EN_ADDR)
  ) u_dec (
    .addr(io_addr), .sel(sel), .byte_idx(byte_idx)
  );

  memhp_bitmap #(.SLOTS(SLOTS)) u_map (
    .clk(clk), .rst(rst),
    .set_valid(hp_add_valid), .set_slot(hp_add_slot),
    .clr_valid(ej_hit), .clr_slot(io_wdata[SLOT_W-1:0]),
    .rd_idx(byte_idx), .rd_byte(map_byte), .pend_flat(pend_flat)
  );

  memhp_gpe u_gpe (
    .clk(clk), .rst(rst),
    .mem_evt(hp_add_valid), .pci_evt(pci_hp_evt),
    .sts_wr(io_wr && sel == SEL_STS), .en_wr(io_wr && sel == SEL_EN),
    .wdata(io_wdata), .pm_sci_in(pm_sci_in),
    .sts(gpe_sts), .en(gpe_en), .sci(sci)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata    <= 8'h00;
      eject_valid <= 1'b0;
      eject_slot  <= '0;
    end else begin
      if (io_rd) begin
        case (sel)
          SEL_MAP: io_rdata <= map_byte;
          SEL_STS: io_rdata <= gpe_sts;
          SEL_EN:  io_rdata <= gpe_en;
          default: io_rdata <= 8'h00;
        endcase
      end
      eject_valid <= ej_hit;
      if (ej_hit) eject_slot <= io_wdata[SLOT_W-1:0];
    end
  end
endmodule

// File: rtl/memhp_ctrl_chk.sv
module memhp_ctrl_chk #(
  parameter int          SLOTS      = 256,
  parameter logic [15:0] EJECT_ADDR = 16'hAFA0,
  parameter logic [15:0] STS_ADDR   = 16'hAFE0,
  localparam int         SLOT_W     = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       io_addr,
  input logic              io_wr,
  input logic [7:0]        io_wdata,
  input logic              hp_add_valid,
  input logic [SLOT_W-1:0] hp_add_slot,
  input logic              pm_sci_in,
  input logic              eject_valid,
  input logic [SLOT_W-1:0] eject_slot,
  input logic              sci,
  input logic [SLOTS-1:0]  pend_flat,
  input logic [7:0]        gpe_sts,
  input logic [7:0]        gpe_en
);
  // R2
  add_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
    hp_add_valid |=> pend_flat[$past(hp_add_slot)]);

  // R3
  map_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!hp_add_valid && !(io_wr && io_addr == EJECT_ADDR)) |=> $stable(pend_flat));

  // R4
  mem_evt_sts_chk: assert property (@(posedge clk) disable iff (rst)
    hp_add_valid |=> gpe_sts[3]);

  // R4
  sts_legal_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (gpe_sts & 8'hF5) == 8'h00);

  // R5
  sci_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!pm_sci_in && (gpe_sts & gpe_en & 8'h0A) == 8'h00) |=> !sci);

  // R5
  sci_pm_chk: assert property (@(posedge clk) disable iff (rst)
    pm_sci_in |=> sci);

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == STS_ADDR && io_wdata[3] && !hp_add_valid) |=> !gpe_sts[3]);

  // R8
  eject_src_chk: assert property (@(posedge clk) disable iff (rst)
    eject_valid |-> ($past(io_wr && io_addr == EJECT_ADDR)
                     && eject_slot == $past(io_wdata[SLOT_W-1:0])));
endmodule

bind memhp_ctrl memhp_ctrl_chk #(
  .SLOTS(SLOTS), .EJECT_ADDR(EJECT_ADDR), .STS_ADDR(STS_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
  .hp_add_valid(hp_add_valid), .hp_add_slot(hp_add_slot), .pm_sci_in(pm_sci_in),
  .eject_valid(eject_valid), .eject_slot(eject_slot), .sci(sci),
  .pend_flat(pend_flat), .gpe_sts(gpe_sts), .gpe_en(gpe_en)
);

// File: tb/sim_memhp_ctrl.sv
`timescale 1ns/1ps
module sim_memhp_ctrl;
  localparam logic [15:0] MB  = 16'hAF80;
  localparam logic [15:0] EJ  = 16'hAFA0;
  localparam logic [15:0] STS = 16'hAFE0;
  localparam logic [15:0] EN  = 16'hAFE1;
  localparam logic [1:0] OP_ADD = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{OP_ADD, 16'd0,   8'd0,    8'h00, 4'd2},
    '{OP_ADD, 16'd7,   8'd0,    8'h00, 4'd2},
    '{OP_ADD, 16'd8,   8'd0,    8'h00, 4'd2},
    '{OP_ADD, 16'd255, 8'd0,    8'h00, 4'd2},
    '{OP_ADD, 16'd100, 8'd0,    8'h00, 4'd2},
    '{OP_RD,  MB,      8'd0,    8'h81, 4'd2},  // R2 slots 0 and 7
    '{OP_RD,  MB+1,    8'd0,    8'h01, 4'd2},  // R2 slot 8
    '{OP_RD,  MB+31,   8'd0,    8'h80, 4'd2},  // R2 slot 255
    '{OP_RD,  MB+12,   8'd0,    8'h10, 4'd2},  // R2 slot 100
    '{OP_WR,  MB,      8'hFF,   8'h00, 4'd3},
    '{OP_RD,  MB,      8'd0,    8'h81, 4'd3},  // R3 write ignored
    '{OP_RD,  MB+32,   8'd0,    8'h00, 4'd7},  // R7 past end (also eject)
    '{OP_RD,  MB-1,    8'd0,    8'h00, 4'd7},  // R7 before window
    '{OP_RD,  STS,     8'd0,    8'h08, 4'd4}   // R4 memory bit latched
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic hp_add_valid = 1'b0;
  logic [7:0] hp_add_slot = '0;
  logic pci_hp_evt = 1'b0, pm_sci_in = 1'b0;
  logic eject_valid;
  logic [7:0] eject_slot;
  logic sci;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  memhp_ctrl u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .hp_add_valid(hp_add_valid),
    .hp_add_slot(hp_add_slot), .pci_hp_evt(pci_hp_evt), .pm_sci_in(pm_sci_in),
    .eject_valid(eject_valid), .eject_slot(eject_slot), .sci(sci)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    d = io_rdata; io_rd = 1'b0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic add_slot(input logic [7:0] s);
    hp_add_slot = s; hp_add_valid = 1'b1;
    @(negedge clk);
    hp_add_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 sci", {7'd0, sci}, 8'h00);
    check("R1 eject_valid", {7'd0, eject_valid}, 8'h00);
    check("R1 rdata", io_rdata, 8'h00);
    io_read(MB + 31, d); check("R1 map", d, 8'h00);
    io_read(STS, d);     check("R1 sts", d, 8'h00);
    io_read(EN, d);      check("R1 en", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_ADD: add_slot(VECS[i].addr[7:0]);
        OP_WR:  io_write(VECS[i].addr, VECS[i].data);
        default: begin
          io_read(VECS[i].addr, d);
          check($sformatf("R%0d vec%0d", VECS[i].req, i), d, VECS[i].exp);
        end
      endcase
    end

    // R5 status pending but enable zero: no interrupt
    check("R5 masked", {7'd0, sci}, 8'h00);
    io_write(EN, 8'h08);
    @(negedge clk);
    check("R5 enabled", {7'd0, sci}, 8'h01);
    io_read(EN, d); check("R10 enable readback", d, 8'h08);
    io_write(EN, 8'hF7); io_read(EN, d); check("R10 enable all bits", d, 8'hF7);
    io_write(EN, 8'h08);

    // R6 zero write keeps, one write clears
    io_write(STS, 8'h00); io_read(STS, d); check("R6 write zero", d, 8'h08);
    check("R6 sci held", {7'd0, sci}, 8'h01);
    io_write(STS, 8'h08);
    @(negedge clk);
    check("R6 sci drop", {7'd0, sci}, 8'h00);
    io_read(STS, d); check("R6 cleared", d, 8'h00);

    // R4 pci event bit
    io_write(EN, 8'h02);
    pci_hp_evt = 1'b1; @(negedge clk); pci_hp_evt = 1'b0;
    @(negedge clk);
    check("R5 pci sci", {7'd0, sci}, 8'h01);
    io_read(STS, d); check("R4 pci bit", d, 8'h02);
    io_write(STS, 8'h02);

    // R6 same-cycle add and clear: set wins
    hp_add_slot = 8'd1; hp_add_valid = 1'b1;
    io_addr = STS; io_wdata = 8'h08; io_wr = 1'b1;
    @(negedge clk);
    hp_add_valid = 1'b0; io_wr = 1'b0;
    io_read(STS, d); check("R6 set wins", d, 8'h08);
    io_write(STS, 8'h08);

    // R5 pass-through of other request
    @(negedge clk);
    pm_sci_in = 1'b1; @(negedge clk);
    check("R5 pm high", {7'd0, sci}, 8'h01);
    pm_sci_in = 1'b0; @(negedge clk);
    check("R5 pm low", {7'd0, sci}, 8'h00);

    // R8 eject slot 7 from byte holding 0x83
    io_read(MB, d); check("R8 pre byte0", d, 8'h83);
    io_addr = EJ; io_wdata = 8'd7; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    check("R8 eject strobe", {7'd0, eject_valid}, 8'h01);
    check("R8 eject slot", eject_slot, 8'd7);
    @(negedge clk);
    check("R8 strobe one cycle", {7'd0, eject_valid}, 8'h00);
    io_read(MB, d); check("R8 only slot cleared", d, 8'h03);

    // R9 same-cycle add and read of byte 2
    hp_add_slot = 8'd17; hp_add_valid = 1'b1;
    io_addr = MB + 2; io_rd = 1'b1;
    @(negedge clk);
    hp_add_valid = 1'b0; io_rd = 1'b0;
    check("R9 old value", io_rdata, 8'h00);
    io_read(MB + 2, d); check("R9 new value", d, 8'h02);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule